// File: doc/BRIEF.md
# Page Translation Buffer

This block holds a small, fully associative set of page-table entries and turns a virtual address into a physical address for fixed 4 KB pages. The low 12 bits of the address are the page offset and pass through unchanged. The bits above them form the virtual page number. That number is compared against every stored entry in the same cycle. A matching entry whose page is resident yields the physical address. A matching entry whose page is marked absent yields a page-fault indication. If no entry matches, the block reports a miss.

After a miss, the page-table walker outside the block supplies the entry on the refill port, and the requester retries the lookup. Each entry keeps a reference bit and a dirty bit. A successful translation sets the reference bit. A successful translation for a store also sets the dirty bit. The values these bits held before the access are returned with the result, so software-visible page state can be kept current.

A refill goes to the entry that already holds the same page number if there is one. Otherwise it goes to the lowest-numbered empty entry. If every entry is full, a free-running LFSR picks the entry to replace. A flush empties the whole buffer in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, res_valid is low and every entry is empty, so the first lookup of any address reports a miss.
- R2: A lookup presented with lk_valid high at a clock edge gives its result at the next edge. At that edge res_valid is high and exactly one of res_hit, res_miss and res_fault is high. Without a lookup, res_valid is low.
- R3: On a hit, res_paddr equals the stored physical page number in bits [PA_W-1:12] and lk_vaddr[11:0] in bits [11:0]. On a miss or a fault, res_paddr is zero.
- R4: On a hit, res_ref_prior and res_dirty_prior return the entry's reference and dirty bits as they stood before the access. The hit sets the reference bit. A hit with lk_write high also sets the dirty bit. A hit with lk_write low leaves the dirty bit unchanged.
- R5: A lookup whose page number matches no valid entry reports a miss. After the entry is refilled, a retried lookup hits.
- R6: A lookup that matches an entry loaded with refill_present low reports a fault and gives no translation.
- R7: A refill loads the entry with its reference and dirty bits cleared. A refill whose page number is already held overwrites that same entry, so no duplicate is created and no other entry is evicted.
- R8: A refill of a new page number fills the lowest-numbered empty entry if one exists. With every entry valid, it replaces exactly one entry chosen by the LFSR.
- R9: flush empties every entry in one cycle. A refill in the same cycle as a flush is discarded.
- R10: A lookup in the same cycle as a refill or a flush sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empties all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | Lookup is for a store |
| refill_valid | input | 1 | Load an entry |
| refill_vpn | input | VA_W-12 | Virtual page number to load |
| refill_ppn | input | PA_W-12 | Physical page number to load |
| refill_present | input | 1 | Page is resident (0 gives faults) |
| res_valid | output | 1 | Result available |
| res_hit | output | 1 | Translation succeeded |
| res_miss | output | 1 | No entry matched |
| res_fault | output | 1 | Entry matched but page is absent |
| res_paddr | output | PA_W | Translated physical address |
| res_ref_prior | output | 1 | Reference bit before this access |
| res_dirty_prior | output | 1 | Dirty bit before this access |

## Verification
Every result is registered, so it appears one clock edge after the lookup is presented. A refill or flush changes what the next lookup sees, not a lookup presented in the same cycle. The bench drives inputs on the falling edge, waits for one rising edge, and samples on the following falling edge. It therefore always reads the result of the single edge that registered the lookup. Cases that share a cycle (a lookup together with a refill, or with a flush) are driven as one falling-edge setup. They are then checked on the edge after that one, against the contents from before it.

// File: rtl/tlb_pkg.sv
// Shared constants for the page translation buffer.
// Assumes fixed 4 KB pages; the offset width is not a parameter of the design.
package tlb_pkg;
    localparam int PAGE_OFS_W = 12;
    localparam int LFSR_W     = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/tlb_match.sv
// Parallel tag comparator: compares one key against every entry in the same
// cycle and encodes the matching position.
// Assumes at most one valid entry carries a given tag. The refill path keeps
// this true by overwriting the entry that already holds a page number.
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 20,
    parameter int IDX_W   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [TAG_W-1:0]                key,
    input  logic [ENTRIES-1:0][TAG_W-1:0]   tags,
    input  logic [ENTRIES-1:0]              valid,
    output logic [ENTRIES-1:0]              hit_vec,
    output logic                            any_hit,
    output logic [IDX_W-1:0]                hit_idx
);
    // one comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    // one-hot to binary encode of the match position
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    assign any_hit = |hit_vec;

    // R7: no two valid entries may ever match the same key
    assert_unique_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/tlb_victim.sv
// Replacement chooser: the lowest-numbered empty entry if there is one,
// otherwise an entry picked by a free-running Galois LFSR.
// Assumes ENTRIES is a power of two so the LFSR index is uniform.
module tlb_victim #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    output logic [IDX_W-1:0]   victim_idx
);
    import tlb_pkg::*;

    logic [LFSR_W-1:0] lfsr_q;
    logic [IDX_W-1:0]  free_idx;
    logic              has_free;

    // advance the pseudo-random sequence every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= LFSR_SEED;
        else        lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? LFSR_TAPS : '0);
    end

    // priority search for the lowest empty slot
    always_comb begin
        free_idx = '0;
        has_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
    end

    // pick an empty slot before evicting anything
    assign victim_idx = has_free ? free_idx : IDX_W'(32'(lfsr_q) % ENTRIES);

    // R8: while any entry is empty, the chosen slot is an empty one
    assert_victim_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid != '1) |-> !valid[victim_idx]);
endmodule

// File: rtl/tlb_xlate.sv
// Fully associative page translation buffer for 4 KB pages.
// Holds ENTRIES page-table entries with valid, present, reference and dirty
// state. A lookup is resolved in one registered stage. Refill and flush take
// effect at the same edge and are seen by later lookups only.
// Assumes the external walker refills only after a reported miss or fault.
module tlb_xlate #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int ENTRIES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   lk_valid,
    input  logic [VA_W-1:0]        lk_vaddr,
    input  logic                   lk_write,
    input  logic                   refill_valid,
    input  logic [VA_W-12-1:0]     refill_vpn,
    input  logic [PA_W-12-1:0]     refill_ppn,
    input  logic                   refill_present,
    output logic                   res_valid,
    output logic                   res_hit,
    output logic                   res_miss,
    output logic                   res_fault,
    output logic [PA_W-1:0]        res_paddr,
    output logic                   res_ref_prior,
    output logic                   res_dirty_prior
);
    import tlb_pkg::*;

    localparam int VPN_W = VA_W - PAGE_OFS_W;
    localparam int PPN_W = PA_W - PAGE_OFS_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
    logic [ENTRIES-1:0]            valid_q, present_q, ref_q, dirty_q;

    logic [ENTRIES-1:0] lk_vec, rf_vec;
    logic               lk_any, rf_any;
    logic [IDX_W-1:0]   lk_idx, rf_idx, victim_idx, rf_target;
    logic               lk_present, lk_hit;

    // lookup comparator
    tlb_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
        .clk(clk), .rst_n(rst_n), .key(lk_vaddr[VA_W-1:PAGE_OFS_W]),
        .tags(vpn_q), .valid(valid_q),
        .hit_vec(lk_vec), .any_hit(lk_any), .hit_idx(lk_idx));

    // refill comparator finds an entry that already holds the page number
    tlb_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_rf_match (
        .clk(clk), .rst_n(rst_n), .key(refill_vpn),
        .tags(vpn_q), .valid(valid_q),
        .hit_vec(rf_vec), .any_hit(rf_any), .hit_idx(rf_idx));

    // replacement choice for new page numbers
    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(valid_q), .victim_idx(victim_idx));

    // decode lookup outcome and refill destination
    always_comb begin
        lk_present = present_q[lk_idx];
        lk_hit     = lk_valid && lk_any && lk_present;
        rf_target  = rf_any ? rf_idx : victim_idx;
    end

    // entry state: status updates first, refill and flush override
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= '0;
            present_q <= '0;
            ref_q     <= '0;
            dirty_q   <= '0;
        end else begin
            if (lk_hit) begin
                ref_q[lk_idx] <= 1'b1;
                if (lk_write) dirty_q[lk_idx] <= 1'b1;
            end
            if (flush) begin
                valid_q <= '0;
            end else if (refill_valid) begin
                valid_q[rf_target]   <= 1'b1;
                present_q[rf_target] <= refill_present;
                ref_q[rf_target]     <= 1'b0;
                dirty_q[rf_target]   <= 1'b0;
            end
        end
    end

    // entry payload, not reset since valid_q guards it
    always_ff @(posedge clk) begin
        if (refill_valid && !flush) begin
            vpn_q[rf_target] <= refill_vpn;
            ppn_q[rf_target] <= refill_ppn;
        end
    end

    // registered lookup result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid       <= 1'b0;
            res_hit         <= 1'b0;
            res_miss        <= 1'b0;
            res_fault       <= 1'b0;
            res_paddr       <= '0;
            res_ref_prior   <= 1'b0;
            res_dirty_prior <= 1'b0;
        end else begin
            res_valid       <= lk_valid;
            res_hit         <= lk_hit;
            res_miss        <= lk_valid && !lk_any;
            res_fault       <= lk_valid && lk_any && !lk_present;
            res_paddr       <= lk_hit ? {ppn_q[lk_idx], lk_vaddr[PAGE_OFS_W-1:0]} : '0;
            res_ref_prior   <= lk_hit && ref_q[lk_idx];
            res_dirty_prior <= lk_hit && dirty_q[lk_idx];
        end
    end

    // R2: one result per lookup, on the next edge
    assert_result_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);
    assert_single_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_hit, res_miss, res_fault}) == 1));
    // R3 / R6: no address leaks out on a miss or fault
    assert_fault_no_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_fault || res_miss) |-> (res_paddr == '0));
    // R4: a hit leaves the entry's reference bit set
    assert_hit_sets_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !refill_valid) |=> ref_q[$past(lk_idx)]);
    // R9: flush empties every entry by the next edge
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
    localparam int VA_W = 32;
    localparam int PA_W = 32;
    localparam int N    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic lk_valid = 1'b0;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic lk_write = 1'b0;
    logic refill_valid = 1'b0;
    logic [VA_W-13:0] refill_vpn = '0;
    logic [PA_W-13:0] refill_ppn = '0;
    logic refill_present = 1'b0;
    logic res_valid, res_hit, res_miss, res_fault, res_ref_prior, res_dirty_prior;
    logic [PA_W-1:0] res_paddr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tlb_xlate #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn),
        .refill_ppn(refill_ppn), .refill_present(refill_present),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_fault(res_fault), .res_paddr(res_paddr),
        .res_ref_prior(res_ref_prior), .res_dirty_prior(res_dirty_prior));

    function automatic logic [19:0] vpn_of(int i);
        return 20'h00040 + 20'(i * 17);
    endfunction
    function automatic logic [19:0] ppn_of(int i);
        return 20'h5A000 + 20'(i * 7);
    endfunction
    function automatic logic [11:0] ofs_of(int i);
        return 12'((i * 37 + 5) & 12'hFFF);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one lookup; result sampled on the falling edge after the registering edge
    task automatic lookup(input logic [19:0] vpn, input logic [11:0] ofs, input bit wr);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {vpn, ofs}; lk_write = wr;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn, input bit pres);
        @(negedge clk);
        refill_valid = 1'b1; refill_vpn = vpn; refill_ppn = ppn; refill_present = pres;
        @(posedge clk);
        @(negedge clk);
        refill_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [19:0] ppn, input logic [11:0] ofs);
        chk(res_valid && res_hit && !res_miss && !res_fault, req, {res_valid, res_hit, res_miss, res_fault}, 4'b1100);
        chk(res_paddr == {ppn, ofs}, req, res_paddr, {ppn, ofs});
    endtask

    task automatic expect_miss(input string req);
        chk(res_valid && res_miss && !res_hit && !res_fault, req, {res_valid, res_hit, res_miss, res_fault}, 4'b1010);
        chk(res_paddr == '0, req, res_paddr, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int hits;
        int evicted;
        int keep;
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R2 idle no result", res_valid, 0);
        lookup(vpn_of(0), 12'h123, 1'b0);
        expect_miss("R1 cold lookup");

        // R5 retry after refill; R8 fill all empty slots without loss
        for (int i = 0; i < N; i++) refill(vpn_of(i), ppn_of(i), 1'b1);
        for (int i = 0; i < N; i++) begin
            lookup(vpn_of(i), ofs_of(i), 1'b0);
            expect_hit("R3 R5 R8 translate", ppn_of(i), ofs_of(i));
            chk(res_ref_prior == 1'b0 && res_dirty_prior == 1'b0, "R7 fresh bits",
                {res_ref_prior, res_dirty_prior}, 0);
            if (i % 2 == 1) begin
                lookup(vpn_of(i), ofs_of(i + 3), 1'b1);
                expect_hit("R4 write hit", ppn_of(i), ofs_of(i + 3));
                chk(res_dirty_prior == 1'b0, "R4 dirty before write", res_dirty_prior, 0);
            end
            lookup(vpn_of(i), ofs_of(i + 1), 1'b0);
            chk(res_ref_prior == 1'b1, "R4 ref set", res_ref_prior, 1);
            chk(res_dirty_prior == 1'(i % 2), "R4 dirty only on write", res_dirty_prior, i % 2);
        end

        lookup(20'hFFFFF, 12'hABC, 1'b0);
        expect_miss("R5 unknown page");

        // R8 full buffer: a new page evicts exactly one entry
        refill(20'hEEEEE, 20'h12345, 1'b1);
        hits = 0; evicted = -1; keep = -1;
        for (int i = 0; i < N; i++) begin
            lookup(vpn_of(i), 12'h000, 1'b0);
            if (res_hit) begin hits++; if (keep < 0) keep = i; end
            else evicted = i;
        end
        chk(hits == N - 1, "R8 single eviction", hits, N - 1);
        lookup(20'hEEEEE, 12'hFED, 1'b0);
        expect_hit("R8 new page", 20'h12345, 12'hFED);

        // R7 refill of a held page overwrites in place
        refill(vpn_of(keep), 20'h0BEEF, 1'b1);
        lookup(vpn_of(keep), 12'h010, 1'b0);
        expect_hit("R7 overwrite", 20'h0BEEF, 12'h010);
        chk(res_ref_prior == 1'b0, "R7 overwrite clears ref", res_ref_prior, 0);
        hits = 0;
        for (int i = 0; i < N; i++) begin
            lookup(vpn_of(i), 12'h000, 1'b0);
            if (res_hit) hits++;
        end
        chk(hits == N - 1, "R7 no extra eviction", hits, N - 1);

        // R6 absent page faults, then becomes valid again
        refill(vpn_of(keep), 20'h0AAAA, 1'b0);
        lookup(vpn_of(keep), 12'h777, 1'b1);
        chk(res_valid && res_fault && !res_hit && !res_miss, "R6 fault",
            {res_valid, res_hit, res_miss, res_fault}, 4'b1001);
        chk(res_paddr == '0, "R6 fault addr", res_paddr, 0);
        refill(vpn_of(keep), 20'h0AAAA, 1'b1);
        lookup(vpn_of(keep), 12'h777, 1'b0);
        expect_hit("R6 after fix", 20'h0AAAA, 12'h777);
        chk(res_dirty_prior == 1'b0, "R6 fault did not dirty", res_dirty_prior, 0);

        // R10 lookup alongside flush sees old contents
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {20'hEEEEE, 12'h001}; flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0; flush = 1'b0;
        expect_hit("R10 lookup with flush", 20'h12345, 12'h001);

        // R9 all entries gone
        for (int i = 0; i < N; i++) begin
            lookup(vpn_of(i), 12'h000, 1'b0);
            chk(res_miss == 1'b1, "R9 flushed", res_miss, 1);
        end

        // R9 refill in the flush cycle is discarded
        @(negedge clk);
        flush = 1'b1; refill_valid = 1'b1; refill_vpn = 20'h00321; refill_ppn = 20'h00999; refill_present = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0; refill_valid = 1'b0;
        lookup(20'h00321, 12'h000, 1'b0);
        expect_miss("R9 refill dropped");

        // R10 lookup alongside refill of the same page misses, retry hits
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {20'h00321, 12'h456};
        refill_valid = 1'b1; refill_vpn = 20'h00321; refill_ppn = 20'h00999; refill_present = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0; refill_valid = 1'b0;
        expect_miss("R10 lookup with refill");
        lookup(20'h00321, 12'h456, 1'b0);
        expect_hit("R10 R5 retry", 20'h00999, 12'h456);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule